// File: doc/BRIEF.md
# Register Rename Map Unit

This unit is the renaming front end of a small out-of-order core whose dispatch stream arrives in program order. Each dispatched instruction names two architectural source registers and, optionally, one architectural destination. In the same cycle the unit returns the physical tag now mapped to each source and whether that tag already holds a result. If the instruction writes a register, the unit also takes a fresh physical tag from a free list, maps the destination to it, and reports the tag that was mapped before.

Because every write gets a new physical tag, later writers never clash with earlier readers or earlier writers of the same architectural register. Execution units announce completion on a tag-only broadcast bus, which sets the ready flag of that tag. Retirement logic returns tags that are no longer needed through a release port. When no free tag is left, an instruction that writes a register is stalled.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and reports ready, and no stall is raised.
- R2: Allocation takes free tags in first-in first-out order. After reset the free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, so the first destination gets tag 8 and the next gets tag 9.
- R3: After an accepted write to architectural register d, a source that names d returns the newly allocated tag with ready low.
- R4: Sources are translated before the destination is updated. A source that equals the destination of the same instruction returns the old mapping.
- R5: A broadcast of tag t makes every later read of t report ready.
- R6: A source whose tag matches the broadcast in the same cycle reports ready in that cycle.
- R7: When the free list is empty, disp_stall_o is high for a valid instruction with a destination write, and that instruction changes no mapping. An instruction without a destination write is never stalled.
- R8: A released tag goes to the tail of the free list and is handed out only after every tag that was already free.
- R9: Two writers to the same architectural register get different tags, and dst_prev_tag_o reports the tag mapped before the write.
- R10: A reallocated tag reports not ready, even if it was ready before it was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Instruction presented for renaming |
| disp_dst_we_i | input | 1 | Instruction writes a destination register |
| disp_dst_i | input | 3 | Architectural destination index |
| disp_src0_i | input | 3 | Architectural index of the first source |
| disp_src1_i | input | 3 | Architectural index of the second source |
| disp_stall_o | output | 1 | Instruction not accepted this cycle (no free tag) |
| src0_tag_o | output | 6 | Physical tag of the first source |
| src0_rdy_o | output | 1 | First source result available |
| src1_tag_o | output | 6 | Physical tag of the second source |
| src1_rdy_o | output | 1 | Second source result available |
| dst_tag_o | output | 6 | Newly allocated destination tag (meaningful when disp_dst_we_i) |
| dst_prev_tag_o | output | 6 | Tag mapped to the destination before this write |
| bcast_valid_i | input | 1 | Completion broadcast valid |
| bcast_tag_i | input | 6 | Tag whose result has been written |
| rel_valid_i | input | 1 | Retirement releases a tag |
| rel_tag_i | input | 6 | Tag returned to the free list |

## Verification
A corrupted map entry shows at once: the next instruction that reads that architectural register returns the wrong tag in the same cycle. A lost or duplicated free-list slot appears as a wrong dst_tag_o at the allocation that reaches it, or as a stall raised too early or too late. The bench drains the list to expose this. A stuck ready flag shows on the first source read of that tag after the broadcast or the reallocation, including the same-cycle bypass.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  parameter int unsigned ARCH_REGS = 8;
  parameter int unsigned PHYS_REGS = 64;
endpackage

// File: rtl/rmu_free_list.sv
module rmu_free_list #(
  parameter int unsigned NUM_ARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NUM_PHYS = rmu_pkg::PHYS_REGS,
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_tag_i,
  output logic [PW-1:0] head_tag_o,
  output logic          empty_o
);
  localparam int unsigned INIT_CNT = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] fifo_q [NUM_PHYS];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++)
        fifo_q[i] <= (i < INIT_CNT) ? PW'(i + NUM_ARCH) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT_CNT);
      cnt_q <= CW'(INIT_CNT);
    end else begin
      if (push_i) begin
        fifo_q[wr_q] <= push_tag_i;
        wr_q         <= wrap_inc(wr_q);
      end
      if (pop_i) rd_q <= wrap_inc(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_tag_o = fifo_q[rd_q];
  assign empty_o    = (cnt_q == '0);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> cnt_q != CW'(NUM_PHYS));
endmodule

// File: rtl/rmu_ready_table.sv
module rmu_ready_table #(
  parameter int unsigned NUM_ARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NUM_PHYS = rmu_pkg::PHYS_REGS,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [PW-1:0] set_tag_i,
  input  logic          clr_i,
  input  logic [PW-1:0] clr_tag_i,
  input  logic [PW-1:0] rd_tag_i [NUM_RD],
  output logic          rd_rdy_o [NUM_RD]
);
  logic [NUM_PHYS-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) vld_q[i] <= (i < NUM_ARCH);
    end else begin
      if (set_i) vld_q[set_tag_i] <= 1'b1;
      if (clr_i) vld_q[clr_tag_i] <= 1'b0;  // allocation wins
    end
  end

  // same-cycle broadcast bypass
  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_rdy_o[g] = vld_q[rd_tag_i[g]] | (set_i && set_tag_i == rd_tag_i[g]);
  end

  // R5
  bcast_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !(clr_i && clr_tag_i == set_tag_i)) |=> vld_q[$past(set_tag_i)]);
  // R10
  alloc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_q[$past(clr_tag_i)]);
endmodule

// File: rtl/rmu_map_table.sv
module rmu_map_table #(
  parameter int unsigned NUM_ARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NUM_PHYS = rmu_pkg::PHYS_REGS,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_tag_i,
  input  logic [AW-1:0] rd_idx_i [NUM_RD],
  output logic [PW-1:0] rd_tag_o [NUM_RD]
);
  logic [PW-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (we_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end

  // reads see the mapping before this cycle's write
  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_tag_o[g] = map_q[rd_idx_i[g]];
  end

  // R3
  map_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> map_q[$past(wr_idx_i)] == $past(wr_tag_i));
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int unsigned NUM_ARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NUM_PHYS = rmu_pkg::PHYS_REGS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          disp_valid_i,
  input  logic          disp_dst_we_i,
  input  logic [AW-1:0] disp_dst_i,
  input  logic [AW-1:0] disp_src0_i,
  input  logic [AW-1:0] disp_src1_i,
  output logic          disp_stall_o,
  output logic [PW-1:0] src0_tag_o,
  output logic          src0_rdy_o,
  output logic [PW-1:0] src1_tag_o,
  output logic          src1_rdy_o,
  output logic [PW-1:0] dst_tag_o,
  output logic [PW-1:0] dst_prev_tag_o,
  input  logic          bcast_valid_i,
  input  logic [PW-1:0] bcast_tag_i,
  input  logic          rel_valid_i,
  input  logic [PW-1:0] rel_tag_i
);
  logic          fl_empty;
  logic [PW-1:0] fl_head;
  logic          alloc;
  logic [AW-1:0] map_rd_idx [3];
  logic [PW-1:0] map_rd_tag [3];
  logic [PW-1:0] rdy_rd_tag [2];
  logic          rdy_rd     [2];

  assign disp_stall_o = disp_valid_i && disp_dst_we_i && fl_empty;
  assign alloc        = disp_valid_i && disp_dst_we_i && !fl_empty;

  rmu_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) free_list_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (alloc),
    .push_i     (rel_valid_i),
    .push_tag_i (rel_tag_i),
    .head_tag_o (fl_head),
    .empty_o    (fl_empty)
  );

  assign map_rd_idx[0] = disp_src0_i;
  assign map_rd_idx[1] = disp_src1_i;
  assign map_rd_idx[2] = disp_dst_i;

  rmu_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_RD(3)) map_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (alloc),
    .wr_idx_i (disp_dst_i),
    .wr_tag_i (fl_head),
    .rd_idx_i (map_rd_idx),
    .rd_tag_o (map_rd_tag)
  );

  assign rdy_rd_tag[0] = map_rd_tag[0];
  assign rdy_rd_tag[1] = map_rd_tag[1];

  rmu_ready_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_RD(2)) ready_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (bcast_valid_i),
    .set_tag_i (bcast_tag_i),
    .clr_i     (alloc),
    .clr_tag_i (fl_head),
    .rd_tag_i  (rdy_rd_tag),
    .rd_rdy_o  (rdy_rd)
  );

  assign src0_tag_o     = map_rd_tag[0];
  assign src1_tag_o     = map_rd_tag[1];
  assign src0_rdy_o     = rdy_rd[0];
  assign src1_rdy_o     = rdy_rd[1];
  assign dst_tag_o      = fl_head;
  assign dst_prev_tag_o = map_rd_tag[2];

  // R9
  waw_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |-> dst_tag_o != dst_prev_tag_o);
  // R7
  stall_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_stall_o |=> dst_prev_tag_o == $past(dst_prev_tag_o) || $past(disp_dst_i) != disp_dst_i);
endmodule

// File: tb/rename_map_unit_tb_top.sv
module rename_map_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dv = 1'b0, dwe = 1'b0, bv = 1'b0, rv = 1'b0;
  logic [2:0] dd = '0, s0 = '0, s1 = '0;
  logic [5:0] bt = '0, rt = '0;
  logic       stall, r0, r1;
  logic [5:0] t0, t1, td, tp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rename_map_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(dv), .disp_dst_we_i(dwe), .disp_dst_i(dd),
    .disp_src0_i(s0), .disp_src1_i(s1), .disp_stall_o(stall),
    .src0_tag_o(t0), .src0_rdy_o(r0), .src1_tag_o(t1), .src1_rdy_o(r1),
    .dst_tag_o(td), .dst_prev_tag_o(tp),
    .bcast_valid_i(bv), .bcast_tag_i(bt),
    .rel_valid_i(rv), .rel_tag_i(rt)
  );

  typedef struct packed {
    logic       we; logic [2:0] dst; logic [2:0] a0; logic [2:0] a1;
    logic       bcv; logic [5:0] bct;
    logic [5:0] e0; logic er0; logic [5:0] e1; logic er1;
    logic [5:0] ed; logic [5:0] ep;
  } vec_t;

  // we dst a0 a1 bcv bct | e0 er0 e1 er1 ed ep
  localparam vec_t VECS [8] = '{
    '{1'b1,3'd0,3'd1,3'd2,1'b0,6'd0,  6'd1, 1'b1,6'd2, 1'b1,6'd8, 6'd0},  // R1 R2
    '{1'b1,3'd3,3'd0,3'd3,1'b0,6'd0,  6'd8, 1'b0,6'd3, 1'b1,6'd9, 6'd3},  // R3 R4
    '{1'b1,3'd0,3'd4,3'd5,1'b0,6'd0,  6'd4, 1'b1,6'd5, 1'b1,6'd10,6'd8},  // R9
    '{1'b0,3'd0,3'd0,3'd3,1'b1,6'd8,  6'd10,1'b0,6'd9, 1'b0,6'd0, 6'd0},
    '{1'b0,3'd0,3'd0,3'd3,1'b1,6'd10, 6'd10,1'b1,6'd9, 1'b0,6'd0, 6'd0},  // R6
    '{1'b0,3'd0,3'd0,3'd3,1'b0,6'd0,  6'd10,1'b1,6'd9, 1'b0,6'd0, 6'd0},  // R5
    '{1'b1,3'd7,3'd7,3'd7,1'b1,6'd7,  6'd7, 1'b1,6'd7, 1'b1,6'd11,6'd7},  // R4
    '{1'b0,3'd0,3'd7,3'd3,1'b1,6'd9,  6'd11,1'b0,6'd9, 1'b1,6'd0, 6'd0}   // R3 R6
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dv = 0; dwe = 0; bv = 0; rv = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset mapping
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dv = 1; dwe = 0; s0 = 3'(i); s1 = 3'(7 - i);
      #1;
      chk("R1 src0 tag", t0, i);
      chk("R1 src0 rdy", r0, 1);
      chk("R1 stall", stall, 0);
    end
    // vector table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dv = 1; dwe = VECS[v].we; dd = VECS[v].dst;
      s0 = VECS[v].a0; s1 = VECS[v].a1;
      bv = VECS[v].bcv; bt = VECS[v].bct;
      #1;
      chk("R3/R4 src0 tag", t0, VECS[v].e0);
      chk("R5/R6 src0 rdy", r0, VECS[v].er0);
      chk("R3/R4 src1 tag", t1, VECS[v].e1);
      chk("R5/R6 src1 rdy", r1, VECS[v].er1);
      if (VECS[v].we) begin
        chk("R2 dst tag", td, VECS[v].ed);
        chk("R9 prev tag", tp, VECS[v].ep);
      end
    end
    // R8 release tag 8 (already broadcast ready) to the tail
    @(negedge clk);
    idle(); rv = 1; rt = 6'd8;
    @(negedge clk);
    idle();
    // R2 drain the rest in order 12..63
    prev = 6'd1;
    for (int k = 12; k < 64; k++) begin
      @(negedge clk);
      dv = 1; dwe = 1; dd = 3'd1; s0 = 3'd1; s1 = 3'd1;
      #1;
      chk("R2 fifo order", td, k);
      chk("R9 prev tag", tp, prev);
      chk("R7 no stall", stall, 0);
      prev = 6'(k);
    end
    // R8 released tag comes after all earlier ones
    @(negedge clk);
    dv = 1; dwe = 1; dd = 3'd2; s0 = 3'd2; s1 = 3'd1;
    #1;
    chk("R8 released tag", td, 8);
    chk("R3 src1 tag", t1, 63);
    chk("R3 src1 rdy", r1, 0);
    // R10 reallocated tag not ready
    @(negedge clk);
    dv = 1; dwe = 0; s0 = 3'd2; s1 = 3'd0;
    #1;
    chk("R10 realloc tag", t0, 8);
    chk("R10 realloc rdy", r0, 0);
    chk("R7 no-dst not stalled", stall, 0);
    // R7 empty list
    @(negedge clk);
    dv = 1; dwe = 1; dd = 3'd5; s0 = 3'd5; s1 = 3'd5;
    #1;
    chk("R7 stall when empty", stall, 1);
    @(negedge clk);
    dv = 1; dwe = 0; s0 = 3'd5; s1 = 3'd6;
    #1;
    chk("R7 map unchanged", t0, 5);
    chk("R7 rdy unchanged", r0, 1);
    chk("R7 no-dst no stall", stall, 0);
    // R8 release refills; next write proceeds
    @(negedge clk);
    idle(); rv = 1; rt = 6'd40;
    @(negedge clk);
    idle(); dv = 1; dwe = 1; dd = 3'd5; s0 = 3'd5; s1 = 3'd5;
    #1;
    chk("R8 refill no stall", stall, 0);
    chk("R8 refill tag", td, 40);
    @(negedge clk);
    idle(); dv = 1; s0 = 3'd5;
    #1;
    chk("R3 new map", t0, 40);
    @(negedge clk);
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule